// File: doc/BRIEF.md
# Reference Clock Switchover Controller

This block picks which of two reference clocks feeds a downstream PLL. It watches both references from a free-running monitor clock and raises a per-reference "stopped" flag when a reference goes quiet. It changes the selection on a software request, on loss of PLL lock, or on a primary that has gone quiet, depending on a build-time mode. The selected clock leaves through a handshaked gate, so the output never carries a runt pulse. A second output reports which reference is in use.

Three modes are fixed by parameter: manual, where only the request moves the selection; automatic, where lock loss or a quiet primary moves it; and automatic with override, where lock loss or the request moves it. An optional pre-switch delay holds the change back until the incoming reference has produced a set number of rising edges. Lock is an external input. The PLL itself is not part of the block.

Top module: `refclk_switchover`

## Requirements
- R1: For the first monitor cycle after reset is released, the active indicator is 0, both stopped flags are 0, and the output carries the primary reference.
- R2: The active indicator reads 0 while the primary reference drives the output and 1 while the secondary does. It changes only at the end of a switch, once the incoming gate is open.
- R3: A reference's stopped flag rises after STOP_TIMEOUT monitor cycles with no synchronized transition of it. It falls only after CLR_EDGES transitions in a row, each arriving within the timeout. It never rises in the cycle after a synchronized rising edge.
- R4: In manual mode (MODE = 0), each rising edge of the request toggles the selection once. Lock and the stopped flags have no effect. A request edge that arrives while a switch is in progress is dropped.
- R5: In automatic mode (MODE = 1), a falling edge of lock starts a switch. So does a set primary stopped flag while the primary is selected. The request has no effect.
- R6: In override mode (MODE = 2), a falling edge of lock or a rising edge of the request starts a switch. A quiet primary on its own does not start one.
- R7: A switch started by lock loss or by a quiet primary never moves to a reference whose stopped flag is set. With both flags set, the selection stays where it is.
- R8: With WAIT_EN = 1, the selection changes only after WAIT_CYC synchronized rising edges of the incoming reference. With WAIT_EN = 0, it changes as soon as the trigger is seen.
- R9: At most one gate passes its reference at any time. The output never shows a high or low phase shorter than the shorter half period of the two references.
- R10: When a switch has settled, the output has the period of the reference named by the active indicator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mon_clk_i | input | 1 | Free-running monitor clock; all control logic runs on it |
| rst_i | input | 1 | Synchronous active-high reset; all clocks must run while it is high |
| ref0_clk_i | input | 1 | Primary reference clock |
| ref1_clk_i | input | 1 | Secondary reference clock |
| lock_i | input | 1 | PLL lock indication; a falling edge means lock was lost |
| swreq_i | input | 1 | Switch request; acted on at its rising edge |
| clk_o | output | 1 | Gated, glitch-free selected reference |
| active_o | output | 1 | 0 = primary in use, 1 = secondary in use |
| bad0_o | output | 1 | Primary reference has stopped |
| bad1_o | output | 1 | Secondary reference has stopped |

## Verification
The bench builds three copies side by side, all with STOP_TIMEOUT = 16 and CLR_EDGES = 8:
- manual mode with the pre-switch delay turned off;
- automatic mode with a 4-edge delay;
- override mode with a 4-edge delay.

Because all three share one stimulus stream, the same lock drop, quiet reference or request is judged against three mode rules at once. The short timeout and recovery count bring stop detection and recovery within about a hundred nanoseconds. Those values also let the bench park one reference high and the other low, and set both flags together. Pairing the delayed override copy with the undelayed manual copy makes the delay measurable as a bound on request-to-indicator time.

// File: rtl/clksw_pkg.sv
`timescale 1ns/1ps
package clksw_pkg;
  typedef enum logic [1:0] {
    SW_MANUAL   = 2'd0,
    SW_AUTO     = 2'd1,
    SW_AUTO_OVR = 2'd2
  } sw_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_SWAP
  } sw_state_e;
endpackage

// File: rtl/clksw_stop_det.sv
`timescale 1ns/1ps
// Watches one reference from the monitor domain and flags it as stopped.
module clksw_stop_det #(
  parameter int STOP_TIMEOUT = 16,
  parameter int CLR_EDGES    = 8
) (
  input  logic mon_clk_i,
  input  logic rst_i,
  input  logic ref_clk_i,
  output logic bad_o,
  output logic rise_o
);
  localparam int IW = $clog2(STOP_TIMEOUT + 1);
  localparam int GW = $clog2(CLR_EDGES + 1);

  logic [2:0]    smp_q;
  logic [IW-1:0] idle_q;
  logic [GW-1:0] good_q;
  logic          toggle;

  // two synchronizer stages plus one history stage
  always_ff @(posedge mon_clk_i) begin
    if (rst_i) smp_q <= '0;
    else       smp_q <= {smp_q[1:0], ref_clk_i};
  end

  assign toggle = smp_q[2] ^ smp_q[1];
  assign rise_o = smp_q[1] & ~smp_q[2];

  always_ff @(posedge mon_clk_i) begin
    if (rst_i) begin
      idle_q <= '0;
      good_q <= '0;
      bad_o  <= 1'b0;
    end else if (toggle) begin
      idle_q <= '0;
      if (bad_o) begin
        if (good_q == GW'(CLR_EDGES - 1)) begin
          bad_o  <= 1'b0;
          good_q <= '0;
        end else begin
          good_q <= good_q + 1'b1;
        end
      end
    end else if (idle_q == IW'(STOP_TIMEOUT - 1)) begin
      bad_o  <= 1'b1;
      good_q <= '0;
    end else begin
      idle_q <= idle_q + 1'b1;
    end
  end
endmodule

// File: rtl/clksw_gate.sv
`timescale 1ns/1ps
// Falling-edge enable for one reference; opens only once the peer gate is shut or its clock is flagged dead.
module clksw_gate (
  input  logic ref_clk_i,
  input  logic rst_i,
  input  logic want_i,
  input  logic peer_en_i,
  input  logic peer_bad_i,
  input  logic own_bad_i,
  output logic en_o,
  output logic pass_o
);
  logic arm_q, en_q, kill_a_q, kill_b_q;

  always_ff @(negedge ref_clk_i) begin
    if (rst_i) begin
      arm_q    <= 1'b0;
      en_q     <= 1'b0;
      kill_a_q <= 1'b0;
      kill_b_q <= 1'b0;
    end else begin
      arm_q    <= want_i & (~peer_en_i | peer_bad_i);
      en_q     <= arm_q;
      kill_a_q <= own_bad_i;
      kill_b_q <= kill_a_q;
    end
  end

  // a stopped clock is masked at once; unmasking waits for a low phase of the restarted clock
  assign en_o   = en_q;
  assign pass_o = en_q & ~own_bad_i & ~kill_b_q;
endmodule

// File: rtl/clksw_ctrl.sv
`timescale 1ns/1ps
// Trigger decode, pre-switch delay and switch sequencing in the monitor domain.
module clksw_ctrl
  import clksw_pkg::*;
#(
  parameter sw_mode_e MODE     = SW_AUTO,
  parameter bit       WAIT_EN  = 1'b1,
  parameter int       WAIT_CYC = 4
) (
  input  logic mon_clk_i,
  input  logic rst_i,
  input  logic req_i,
  input  logic lock_i,
  input  logic bad0_i,
  input  logic bad1_i,
  input  logic rise0_i,
  input  logic rise1_i,
  input  logic en0_i,
  input  logic en1_i,
  output logic sel_o,
  output logic active_o,
  output logic busy_o
);
  localparam bit USE_REQ  = (MODE != SW_AUTO);
  localparam bit USE_LOCK = (MODE != SW_MANUAL);
  localparam bit USE_STOP = (MODE == SW_AUTO);
  localparam bit DO_WAIT  = WAIT_EN && (WAIT_CYC > 0);
  localparam int CW       = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;

  logic [2:0]    req_q, lock_q;
  logic [1:0]    en0_q, en1_q;
  logic [CW-1:0] cnt_q;
  sw_state_e     state_q;
  logic          req_rise, lock_fall, peer_bad, go, tgt_rise, tgt_en;

  always_ff @(posedge mon_clk_i) begin
    if (rst_i) begin
      req_q  <= '0;
      lock_q <= '0;
      en0_q  <= '0;
      en1_q  <= '0;
    end else begin
      req_q  <= {req_q[1:0], req_i};
      lock_q <= {lock_q[1:0], lock_i};
      en0_q  <= {en0_q[0], en0_i};
      en1_q  <= {en1_q[0], en1_i};
    end
  end

  assign req_rise  = req_q[1] & ~req_q[2];
  assign lock_fall = ~lock_q[1] & lock_q[2];
  assign peer_bad  = sel_o ? bad0_i : bad1_i;
  assign go = (USE_REQ & req_rise) |
              (((USE_LOCK & lock_fall) | (USE_STOP & ~sel_o & bad0_i)) & ~peer_bad);
  // in WAIT the target is the unselected side; in SWAP sel_o already names it
  assign tgt_rise  = sel_o ? rise0_i : rise1_i;
  assign tgt_en    = sel_o ? en1_q[1] : en0_q[1];
  assign busy_o    = (state_q != ST_IDLE);

  always_ff @(posedge mon_clk_i) begin
    if (rst_i) begin
      state_q  <= ST_IDLE;
      sel_o    <= 1'b0;
      active_o <= 1'b0;
      cnt_q    <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (go) begin
          if (DO_WAIT) begin
            cnt_q   <= '0;
            state_q <= ST_WAIT;
          end else begin
            sel_o   <= ~sel_o;
            state_q <= ST_SWAP;
          end
        end
        ST_WAIT: if (tgt_rise) begin
          if (cnt_q == CW'(WAIT_CYC - 1)) begin
            sel_o   <= ~sel_o;
            state_q <= ST_SWAP;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_SWAP: if (tgt_en) begin
          active_o <= sel_o;
          state_q  <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/refclk_switchover.sv
`timescale 1ns/1ps
module refclk_switchover
  import clksw_pkg::*;
#(
  parameter sw_mode_e MODE         = SW_AUTO,
  parameter bit       WAIT_EN      = 1'b1,
  parameter int       WAIT_CYC     = 4,
  parameter int       STOP_TIMEOUT = 16,
  parameter int       CLR_EDGES    = 8
) (
  input  logic mon_clk_i,
  input  logic rst_i,
  input  logic ref0_clk_i,
  input  logic ref1_clk_i,
  input  logic lock_i,
  input  logic swreq_i,
  output logic clk_o,
  output logic active_o,
  output logic bad0_o,
  output logic bad1_o
);
  localparam int NREF = 2;

  logic [NREF-1:0] ref_clk, bad, rise, en, pass;
  logic            sel, busy;

  assign ref_clk = {ref1_clk_i, ref0_clk_i};

  for (genvar i = 0; i < NREF; i++) begin : g_ref
    clksw_stop_det #(
      .STOP_TIMEOUT(STOP_TIMEOUT),
      .CLR_EDGES   (CLR_EDGES)
    ) u_det (
      .mon_clk_i(mon_clk_i),
      .rst_i    (rst_i),
      .ref_clk_i(ref_clk[i]),
      .bad_o    (bad[i]),
      .rise_o   (rise[i])
    );

    clksw_gate u_gate (
      .ref_clk_i (ref_clk[i]),
      .rst_i     (rst_i),
      .want_i    ((i == 1) ? sel : ~sel),
      .peer_en_i (en[NREF-1-i]),
      .peer_bad_i(bad[NREF-1-i]),
      .own_bad_i (bad[i]),
      .en_o      (en[i]),
      .pass_o    (pass[i])
    );
  end

  clksw_ctrl #(
    .MODE    (MODE),
    .WAIT_EN (WAIT_EN),
    .WAIT_CYC(WAIT_CYC)
  ) u_ctrl (
    .mon_clk_i(mon_clk_i),
    .rst_i    (rst_i),
    .req_i    (swreq_i),
    .lock_i   (lock_i),
    .bad0_i   (bad[0]),
    .bad1_i   (bad[1]),
    .rise0_i  (rise[0]),
    .rise1_i  (rise[1]),
    .en0_i    (en[0]),
    .en1_i    (en[1]),
    .sel_o    (sel),
    .active_o (active_o),
    .busy_o   (busy)
  );

  assign clk_o  = |(ref_clk & pass);
  assign bad0_o = bad[0];
  assign bad1_o = bad[1];
endmodule

// File: rtl/clksw_chk.sv
`timescale 1ns/1ps
module clksw_chk (
  input logic       mon_clk_i,
  input logic       rst_i,
  input logic [1:0] pass_i,
  input logic [1:0] rise_i,
  input logic [1:0] bad_i,
  input logic       active_i,
  input logic       busy_i,
  input logic       sel_i
);
  p_reset_default_r1: assert property (@(posedge mon_clk_i) disable iff (rst_i)
    $fell(rst_i) |-> (!active_i && !sel_i && bad_i == 2'b00));

  p_one_gate_open_r9: assert property (@(posedge mon_clk_i) disable iff (rst_i)
    $countones(pass_i) <= 1);

  p_bad0_quiet_r3: assert property (@(posedge mon_clk_i) disable iff (rst_i)
    rise_i[0] |=> !$rose(bad_i[0]));

  p_bad1_quiet_r3: assert property (@(posedge mon_clk_i) disable iff (rst_i)
    rise_i[1] |=> !$rose(bad_i[1]));

  p_active_at_end_r2: assert property (@(posedge mon_clk_i) disable iff (rst_i)
    !$stable(active_i) |-> ($past(busy_i) && active_i == sel_i));
endmodule

bind refclk_switchover clksw_chk chk_i (
  .mon_clk_i(mon_clk_i),
  .rst_i    (rst_i),
  .pass_i   (pass),
  .rise_i   (rise),
  .bad_i    (bad),
  .active_i (active_o),
  .busy_i   (busy),
  .sel_i    (sel)
);

// File: tb/refclk_switchover_tb_top.sv
`timescale 1ns/1ps
module refclk_switchover_tb_top;
  import clksw_pkg::*;

  logic mon_clk = 1'b0, rst = 1'b1, c0 = 1'b0, c1 = 1'b0;
  logic run0 = 1'b1, run1 = 1'b1, lock = 1'b1, req = 1'b0;
  logic [2:0] clk_o, act, b0, b1;

  always #2 mon_clk = ~mon_clk;                 // 250 MHz
  always begin #10; if (run0) c0 = ~c0; end     // 20 ns primary
  always begin #14; if (run1) c1 = ~c1; end     // 28 ns secondary

  refclk_switchover #(.MODE(SW_MANUAL), .WAIT_EN(1'b0), .WAIT_CYC(4)) dut_i (
    .mon_clk_i(mon_clk), .rst_i(rst), .ref0_clk_i(c0), .ref1_clk_i(c1),
    .lock_i(lock), .swreq_i(req), .clk_o(clk_o[0]), .active_o(act[0]),
    .bad0_o(b0[0]), .bad1_o(b1[0]));
  refclk_switchover #(.MODE(SW_AUTO), .WAIT_EN(1'b1), .WAIT_CYC(4)) dut_auto_i (
    .mon_clk_i(mon_clk), .rst_i(rst), .ref0_clk_i(c0), .ref1_clk_i(c1),
    .lock_i(lock), .swreq_i(req), .clk_o(clk_o[1]), .active_o(act[1]),
    .bad0_o(b0[1]), .bad1_o(b1[1]));
  refclk_switchover #(.MODE(SW_AUTO_OVR), .WAIT_EN(1'b1), .WAIT_CYC(4)) dut_ovr_i (
    .mon_clk_i(mon_clk), .rst_i(rst), .ref0_clk_i(c0), .ref1_clk_i(c1),
    .lock_i(lock), .swreq_i(req), .clk_o(clk_o[2]), .active_o(act[2]),
    .bad0_o(b0[2]), .bad1_o(b1[2]));

  int  vec_cnt = 0, err_cnt = 0;
  bit  armed = 1'b0;

  // R9: every phase of each output clock is timed
  for (genvar g = 0; g < 3; g++) begin : g_mon
    real last_t = 0.0;
    int  glitch_n = 0;
    always @(clk_o[g]) begin
      if (armed && ($realtime - last_t) < 9.0) glitch_n++;
      last_t = $realtime;
    end
  end

  // action codes: 1 request pulse, 2 lock low, 3 lock high, 4 park primary high,
  // 5 park secondary low, 7 restart primary, 8 restart secondary
  // fields: act[8:5], manual[4], auto[3], override[2], bad0[1], bad1[0]
  localparam int NSTEP = 19;
  localparam logic [8:0] STEPS [NSTEP] = '{
    {4'd1, 5'b10100}, {4'd1, 5'b00000}, {4'd2, 5'b01100}, {4'd3, 5'b01100},
    {4'd2, 5'b00000}, {4'd3, 5'b00000}, {4'd4, 5'b01010}, {4'd2, 5'b01110},
    {4'd3, 5'b01110}, {4'd7, 5'b01100}, {4'd5, 5'b01101}, {4'd2, 5'b00001},
    {4'd3, 5'b00001}, {4'd4, 5'b00011}, {4'd2, 5'b00011}, {4'd3, 5'b00011},
    {4'd7, 5'b00001}, {4'd8, 5'b00000}, {4'd1, 5'b10100}
  };

  task automatic chk(input string tag, input int got, input int exp);
    vec_cnt++;
    if (got !== exp) begin
      err_cnt++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge mon_clk);
    @(negedge mon_clk);
  endtask

  task automatic apply(input logic [3:0] a);
    case (a)
      4'd1: begin req = 1'b1; repeat (10) @(posedge mon_clk); req = 1'b0; end
      4'd2: lock = 1'b0;
      4'd3: lock = 1'b1;
      4'd4: begin @(posedge c0); #1 run0 = 1'b0; end
      4'd5: begin @(negedge c1); #1 run1 = 1'b0; end
      4'd7: run0 = 1'b1;
      4'd8: run1 = 1'b1;
      default: ;
    endcase
  endtask

  task automatic period_of0(output real p);
    real t;
    @(posedge clk_o[0]); t = $realtime;
    @(posedge clk_o[0]); p = $realtime - t;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
  endtask

  initial begin
    #400000;
    err_cnt++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    real p, t0, tm, to;
    repeat (20) @(posedge mon_clk);
    rst = 1'b0;
    settle(100);
    armed = 1'b1;
    // R1 reset state
    for (int k = 0; k < 3; k++) begin
      chk("R1 active", int'(act[k]), 0);
      chk("R1 bad0", int'(b0[k]), 0);
      chk("R1 bad1", int'(b1[k]), 0);
    end
    period_of0(p);
    chk("R1 R10 period", int'(p), 20);

    // table walk
    for (int s = 0; s < NSTEP; s++) begin
      logic [8:0] v;
      v = STEPS[s];
      apply(v[8:5]);
      settle(400);
      chk("R4 manual", int'(act[0]), int'(v[4]));
      chk((v[1] | v[0]) ? "R7 auto" : "R5 auto", int'(act[1]), int'(v[3]));
      chk("R6 override", int'(act[2]), int'(v[2]));
      for (int k = 0; k < 3; k++) begin
        chk("R3 bad0", int'(b0[k]), int'(v[1]));
        chk("R3 bad1", int'(b1[k]), int'(v[0]));
      end
    end

    // R2 / R10: manual copy now runs on the secondary
    chk("R2 encoding", int'(act[0]), 1);
    period_of0(p);
    chk("R10 period", int'(p), 28);

    // R3 stop and recovery timing on the secondary
    @(negedge c1); #1 run1 = 1'b0;
    #40;  chk("R3 not yet set", int'(b1[1]), 0);
    #110; chk("R3 set", int'(b1[1]), 1);
    chk("R6 quiet ignored", int'(act[2]), 1);
    run1 = 1'b1;
    #50;  chk("R3 held during recovery", int'(b1[1]), 1);
    #400; chk("R3 cleared", int'(b1[1]), 0);
    settle(50);

    // R4: second request edge lands while the first switch is busy
    req = 1'b1; repeat (2) @(posedge mon_clk); req = 1'b0;
    repeat (4) @(posedge mon_clk);
    req = 1'b1; repeat (2) @(posedge mon_clk); req = 1'b0;
    settle(400);
    chk("R4 busy drop", int'(act[0]), 0);
    chk("R6 busy drop", int'(act[2]), 0);
    chk("R5 request ignored", int'(act[1]), 0);

    // R8: delayed versus immediate switch to the secondary
    @(negedge mon_clk);
    t0 = $realtime; tm = 0.0; to = 0.0;
    req = 1'b1;
    fork
      begin @(posedge act[0]); tm = $realtime - t0; end
      begin @(posedge act[2]); to = $realtime - t0; end
    join
    req = 1'b0;
    chk("R8 delay honoured", int'(to >= 90.0), 1);
    chk("R8 delay bounded", int'(to <= 400.0), 1);
    chk("R8 no delay", int'(tm <= 160.0), 1);
    settle(100);

    for (int k = 0; k < 3; k++) ;
    chk("R9 glitch manual", g_mon[0].glitch_n, 0);
    chk("R9 glitch auto", g_mon[1].glitch_n, 0);
    chk("R9 glitch override", g_mon[2].glitch_n, 0);

    summary();
    $finish;
  end
endmodule